// File: doc/BRIEF.md
# Sparse Radix-2 Parallel-Prefix Adder

This block adds two unsigned operands and a carry-in in one combinational pass and returns the sum together with the carry-out. Every operand bit first yields a generate term (both bits set) and a propagate term (the bits differ). Adjacent bit pairs are then merged into two-bit spans. A logarithmic tree of two-input merge nodes runs over those spans. The merge rule is: the joined generate equals the upper generate OR (upper propagate AND lower generate), and the joined propagate equals the AND of both propagates.

Because the tree works on pairs, it yields carries only out of every odd bit (1, 3, 5, ...). The carry out of each even bit is rebuilt by one local step: that bit's generate, or its propagate AND the tree carry just below it. For bit 0, the carry-in takes the place of that tree carry. The carry-in itself enters the tree as the generate term of a virtual position just below bit 0, so every tree output is a complete carry. Each sum bit is the bit's propagate XOR the carry arriving into it.

The word width is a parameter. The default is 16 bits; any even width of at least 4 is accepted. The block has no registers, so results follow the inputs in the same cycle.

Top module: `sparse_prefix_adder`

## Requirements
- R1: For any operands and carry-in, {carry_out, sum} equals opa + opb + carry_in as a (WIDTH+1)-bit unsigned value.
- R2: With carry_in = 1 the result is one greater than with carry_in = 0 for the same operands, including the wrap from all ones to zero.
- R3: When every bit position propagates (opa XOR opb all ones), the carry-in passes the whole word: sum is all ones and carry_out is 0 for carry_in = 0; sum is zero and carry_out is 1 for carry_in = 1.
- R4: With carry_in = 0 and opa AND opb = 0, no carry is formed: sum equals opa OR opb and carry_out is 0. All-zero inputs give a zero sum and a zero carry_out.
- R5: A carry generated at any single bit i (opa = opb = 1 << i, carry_in = 0) appears only at bit i+1 of the sum. When i is the top bit, it appears at carry_out instead. This holds both for even positions, whose carries are rebuilt locally, and for odd positions, whose carries come from the tree.
- R6: The outputs are a combinational function of the current inputs: a new input value is reflected at the outputs within the same clock cycle, with no latency and no dependence on earlier inputs.
- R7: An 8-bit configuration (WIDTH = 8) meets R1 for all 2^17 combinations of operands and carry-in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand, unsigned |
| opb | input | WIDTH | Second operand, unsigned |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of the total |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
A wrong tree node corrupts the carry out of one odd bit. That error shows in the sum bit just above it, and it ripples upward through every higher sum bit that propagates. The locally rebuilt even carry and each sum bit depend on it. Because the block holds no state, any such fault is visible in the very cycle the triggering operands are applied. The bench therefore compares every vector in that cycle. It uses single-bit generate patterns for each position, carry-in chains through the full word, and an exhaustive 8-bit sweep that reaches every span combination.

// File: rtl/sparse_add_pkg.sv
package sparse_add_pkg;

   // Group generate / propagate pair for one span of bits
   typedef struct packed {
      logic g;
      logic p;
   } span_gp_t;

   // Merge an upper span with the span directly below it
   function automatic span_gp_t span_join(input span_gp_t hi, input span_gp_t lo);
      span_gp_t r;
      r.g = hi.g | (hi.p & lo.g);
      r.p = hi.p & lo.p;
      return r;
   endfunction

endpackage

// File: rtl/spa_bitgen.sv
module spa_bitgen #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   output logic [WIDTH-1:0] gen,
   output logic [WIDTH-1:0] prop
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("spa_bitgen: WIDTH must be positive");
      end
   endgenerate

   genvar i;
   generate
      for (i = 0; i < WIDTH; i++) begin : g_bit
         assign gen[i]  = opa[i] & opb[i];
         assign prop[i] = opa[i] ^ opb[i];
      end
   endgenerate

endmodule

// File: rtl/spa_prefix_tree.sv
module spa_prefix_tree
   import sparse_add_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0]   gen,
   input  logic [WIDTH-1:0]   prop,
   input  logic               carry_in,
   output logic [WIDTH/2-1:0] odd_carry
);

   localparam int NPAIR  = WIDTH / 2;
   localparam int LEVELS = (NPAIR > 1) ? $clog2(NPAIR) : 1;

   generate
      if ((WIDTH % 2) != 0 || WIDTH < 4) begin : g_bad_width
         $error("spa_prefix_tree: WIDTH must be even and at least 4");
      end
   endgenerate

   logic [NPAIR-1:0] pair_g;
   logic [NPAIR-1:0] pair_p;

   genvar m, l;
   generate
      for (m = 0; m < NPAIR; m++) begin : g_pair
         span_gp_t hi_s, lo_s, joined;
         assign hi_s   = '{g: gen[2*m+1], p: prop[2*m+1]};
         assign lo_s   = '{g: gen[2*m],   p: prop[2*m]};
         assign joined = span_join(hi_s, lo_s);
         if (m == 0) begin : g_fold_cin
            // carry-in acts as generate of position -1; span then starts at -1
            span_gp_t cin_s, folded;
            assign cin_s    = '{g: carry_in, p: 1'b0};
            assign folded   = span_join(joined, cin_s);
            assign pair_g[m] = folded.g;
            assign pair_p[m] = folded.p;
         end else begin : g_plain
            assign pair_g[m] = joined.g;
            assign pair_p[m] = joined.p;
         end
      end

      for (l = 0; l < LEVELS; l++) begin : g_lvl
         localparam int DIST = 1 << l;
         logic [NPAIR-1:0] g_in, p_in, g_out, p_out;
         if (l == 0) begin : g_src_pair
            assign g_in = pair_g;
            assign p_in = pair_p;
         end else begin : g_src_prev
            assign g_in = g_lvl[l-1].g_out;
            assign p_in = g_lvl[l-1].p_out;
         end
         for (m = 0; m < NPAIR; m++) begin : g_node
            if (m >= DIST) begin : g_join
               span_gp_t a_s, b_s, r_s;
               assign a_s = '{g: g_in[m],      p: p_in[m]};
               assign b_s = '{g: g_in[m-DIST], p: p_in[m-DIST]};
               assign r_s = span_join(a_s, b_s);
               assign g_out[m] = r_s.g;
               assign p_out[m] = r_s.p;
            end else begin : g_pass
               assign g_out[m] = g_in[m];
               assign p_out[m] = p_in[m];
            end
         end
      end
   endgenerate

   assign odd_carry = g_lvl[LEVELS-1].g_out;

   // Checks against the raw bit terms, independent of the tree structure
   always_comb begin
      for (int k = 0; k < NPAIR; k++) begin
         logic [WIDTH-1:0] span_mask;
         span_mask = {WIDTH{1'b1}} >> (WIDTH - 2*k - 2);
         // R3
         full_prop_chk: assert (((prop & span_mask) != span_mask) || (odd_carry[k] == carry_in))
            else $error("tree carry %0d does not follow carry_in through a propagating span", k);
         // R4
         no_gen_chk: assert (((gen & span_mask) != '0) || carry_in || !odd_carry[k])
            else $error("tree carry %0d set without any generate source", k);
      end
   end

endmodule

// File: rtl/spa_carry_fill.sv
module spa_carry_fill #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0]   gen,
   input  logic [WIDTH-1:0]   prop,
   input  logic               carry_in,
   input  logic [WIDTH/2-1:0] odd_carry,
   output logic [WIDTH-1:0]   sum,
   output logic               carry_out
);

   localparam int NPAIR = WIDTH / 2;

   generate
      if ((WIDTH % 2) != 0 || WIDTH < 4) begin : g_bad_width
         $error("spa_carry_fill: WIDTH must be even and at least 4");
      end
   endgenerate

   // cy[i] is the carry out of bit i
   logic [WIDTH-1:0] cy;

   genvar m, i;
   generate
      for (m = 0; m < NPAIR; m++) begin : g_rebuild
         logic below;
         if (m == 0) begin : g_base
            assign below = carry_in;
         end else begin : g_upper
            assign below = odd_carry[m-1];
         end
         assign cy[2*m]   = gen[2*m] | (prop[2*m] & below);
         assign cy[2*m+1] = odd_carry[m];
      end

      for (i = 0; i < WIDTH; i++) begin : g_sum
         if (i == 0) begin : g_lsb
            assign sum[i] = prop[i] ^ carry_in;
         end else begin : g_rest
            assign sum[i] = prop[i] ^ cy[i-1];
         end
      end
   endgenerate

   assign carry_out = cy[WIDTH-1];

   // A non-propagating odd bit fixes the tree carry to that bit's generate
   always_comb begin
      for (int k = 0; k < NPAIR; k++) begin
         // R5
         odd_local_chk: assert (prop[2*k+1] || (odd_carry[k] == gen[2*k+1]))
            else $error("tree carry %0d disagrees with its own bit", k);
      end
   end

endmodule

// File: rtl/sparse_prefix_adder.sv
module sparse_prefix_adder #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             carry_in,
   output logic [WIDTH-1:0] sum,
   output logic             carry_out
);

   localparam int NPAIR = WIDTH / 2;
   localparam int TOTW  = WIDTH + 1;

   generate
      if ((WIDTH % 2) != 0 || WIDTH < 4) begin : g_bad_width
         $error("sparse_prefix_adder: WIDTH must be even and at least 4");
      end
   endgenerate

   logic [WIDTH-1:0] gen_w;
   logic [WIDTH-1:0] prop_w;
   logic [NPAIR-1:0] odd_cy_w;

   spa_bitgen #(.WIDTH(WIDTH)) u_bitgen (
      .opa  (opa),
      .opb  (opb),
      .gen  (gen_w),
      .prop (prop_w)
   );

   spa_prefix_tree #(.WIDTH(WIDTH)) u_tree (
      .gen       (gen_w),
      .prop      (prop_w),
      .carry_in  (carry_in),
      .odd_carry (odd_cy_w)
   );

   spa_carry_fill #(.WIDTH(WIDTH)) u_fill (
      .gen       (gen_w),
      .prop      (prop_w),
      .carry_in  (carry_in),
      .odd_carry (odd_cy_w),
      .sum       (sum),
      .carry_out (carry_out)
   );

   always_comb begin
      // R1
      total_sum_chk: assert ({carry_out, sum} ==
                             (TOTW'(opa) + TOTW'(opb) + TOTW'(carry_in)))
         else $error("adder total differs from arithmetic sum");
   end

endmodule

// File: tb/test_sparse_prefix_adder.sv
module test_sparse_prefix_adder;

   localparam int W  = 16;
   localparam int W8 = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic [W-1:0]  a16, b16, s16;
   logic          c16, co16;
   logic [W8-1:0] a8, b8, s8;
   logic          c8, co8;

   int n_cmp  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   sparse_prefix_adder #(.WIDTH(W)) i_sparse_prefix_adder (
      .opa(a16), .opb(b16), .carry_in(c16), .sum(s16), .carry_out(co16)
   );

   sparse_prefix_adder #(.WIDTH(W8)) i_sparse_prefix_adder_w8 (
      .opa(a8), .opb(b8), .carry_in(c8), .sum(s8), .carry_out(co8)
   );

   task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Apply one 16-bit vector after a rising edge and compare at the next falling edge
   task automatic apply16(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic ci, input logic [W:0] exp);
      @(posedge clk);
      #1;
      a16 = a; b16 = b; c16 = ci;
      @(negedge clk);
      check(req, {co16, s16}, exp);
   endtask

   function automatic logic [W:0] ref16(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci);
      int unsigned t;
      t = int'(a) + int'(b) + int'(ci);
      return t[W:0];
   endfunction

   initial begin
      a16 = '0; b16 = '0; c16 = 1'b0;
      a8  = '0; b8  = '0; c8  = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R4: zero inputs during reset give zero outputs
      check("R4 reset zero", {co16, s16}, 17'h0);
      rst_n = 1'b1;

      // R2: carry-in adds one, including wrap
      apply16("R2 cin adds one", 16'h1234, 16'h1111, 1'b1, 17'h02346);
      apply16("R2 cin zero",     16'h1234, 16'h1111, 1'b0, 17'h02345);
      apply16("R2 wrap",         16'hFFFF, 16'h0000, 1'b1, 17'h10000);

      // R3: full propagate chains
      apply16("R3 alt prop cin1", 16'hAAAA, 16'h5555, 1'b1, 17'h10000);
      apply16("R3 alt prop cin0", 16'hAAAA, 16'h5555, 1'b0, 17'h0FFFF);
      apply16("R3 ones prop cin0", 16'hFFFF, 16'h0000, 1'b0, 17'h0FFFF);

      // R4: disjoint operands, no carry
      apply16("R4 disjoint nibbles", 16'hF0F0, 16'h0F0F, 1'b0, 17'h0FFFF);
      apply16("R4 disjoint sparse",  16'h1248, 16'h8421, 1'b0, 17'h09669);

      // R5: single generate at each position, even (rebuilt) and odd (tree)
      for (int i = 0; i < W; i++) begin
         logic [W-1:0] v;
         v = 16'h1 << i;
         apply16((i % 2 == 0) ? "R5 even generate" : "R5 odd generate",
                 v, v, 1'b0, 17'h1 << (i + 1));
      end

      // R6: back-to-back vectors each seen in their own cycle
      apply16("R6 same cycle a", 16'h00FF, 16'h0001, 1'b0, 17'h00100);
      apply16("R6 same cycle b", 16'h0001, 16'h0001, 1'b0, 17'h00002);
      apply16("R6 same cycle c", 16'h8000, 16'h8000, 1'b1, 17'h10001);

      // R7 exhaustive 8-bit sweep; R1 random 16-bit vectors alongside
      for (int ci = 0; ci < 2; ci++) begin
         for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
               logic [W-1:0] ra, rb;
               logic         rc;
               int           t8;
               ra = W'($urandom);
               rb = W'($urandom);
               rc = 1'($urandom);
               @(posedge clk);
               #1;
               a8 = W8'(a); b8 = W8'(b); c8 = 1'(ci);
               a16 = ra; b16 = rb; c16 = rc;
               @(negedge clk);
               t8 = a + b + ci;
               check("R7 exhaustive w8", {8'h0, co8, s8}, {8'h0, 9'(t8)});
               check("R1 random w16", {co16, s16}, ref16(ra, rb, rc));
            end
         end
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end

   // Watchdog
   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
         $finish;
      end
   end

endmodule